// File: doc/BRIEF.md
# Synchronous Byte Shift Port

This block moves one byte at a time over a two-wire synchronous link. One wire carries data in either direction. The other carries a shift clock that this block always drives. A free-running slot counter divides time into machine cycles of twelve system clocks. Each cycle has six states, S1 to S6, and each state has two phases, P1 and P2. Slot 0 is S1P1, slot 4 is S3P1, slot 9 is S5P2 and slot 11 is S6P2. Every action of the port is tied to one of these slots.

A byte write starts a transmission. The byte goes into a nine-bit shift register with a marker 1 above it. The marker reaching the bottom of the register signals that the byte is complete, so no bit counter is needed. Raising the receive enable while the receive-done flag is clear starts a reception. The receive register is preset with a single 0 at its bottom and 1s above it. When that 0 reaches the top, the last bit is being taken in. Both done flags stay set until they are cleared through their own clear inputs.

Timing terms used below:
- The machine cycle in which the write or start condition is sampled is cycle 0.
- "Visible in slot k of cycle n" means the output holds that value while the slot counter reads k in cycle n.
- An input is sampled in slot k when it is held during slot k and taken at the clock edge that closes slot k.

Top module: `serial_sync_port`

## Requirements
- R1: After reset the slot counter starts at slot 0. The shift clock is high, data output enable is 0, and both active outputs and both done flags are 0. The received byte reads 0.
- R2: A byte write sampled in any slot of cycle 0, while the port is idle, makes xmit_active visible from slot 0 of cycle 2. Cycle 1 passes with xmit_active low.
- R3: While xmit_active is high, the data output enable is 1. The data output carries bit k of the written byte (bit 0 first) for all of cycle 2+k, for k = 0 to 7, and changes only between slot 11 and slot 0.
- R4: The shift clock is low in slots 4 to 9 (S3 to S5) of every cycle in which xmit_active or recv_active is high. It is high at all other times, including when idle.
- R5: xmit_active is last high in slot 0 of cycle 10. From slot 1 of cycle 10, xmit_active is 0 and tx_done is 1.
- R6: A reception starts when rx_en is 1, rx_done is 0 and no transfer is pending or active. recv_active is visible from slot 1 of cycle 2 and stays high up to slot 0 of cycle 10.
- R7: The data pin value sampled in slot 9 (S5P2) of cycle 2+k becomes bit k of the received byte, for k = 0 to 7. Values present in other slots have no effect.
- R8: From slot 1 of cycle 10, recv_active is 0, rx_done is 1 and the received byte is valid. The data output enable stays 0 for the whole reception.
- R9: Each done flag stays set until its clear input is sampled high. If a set and a clear fall in the same cycle, the set wins. While rx_done is 1, a held rx_en starts nothing and the received byte is unchanged.
- R10: Only one transfer runs at a time. A byte write is ignored while any transfer is pending or active, and a reception does not start during a transmission. If a write and a start condition are sampled in the same slot, the write is taken and no reception starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_i | input | 1 | Byte write strobe, one clock |
| wr_data_i | input | DATA_W | Byte to transmit |
| rx_en_i | input | 1 | Receive enable |
| tx_done_clr_i | input | 1 | Clears tx_done_o |
| rx_done_clr_i | input | 1 | Clears rx_done_o |
| sdat_i | input | 1 | Data pin input value |
| sdat_o | output | 1 | Data pin output value |
| sdat_oe_o | output | 1 | Data pin output enable |
| sclk_o | output | 1 | Shift clock pin |
| xmit_active_o | output | 1 | Transmission in progress on the pins |
| recv_active_o | output | 1 | Reception in progress on the pins |
| tx_done_o | output | 1 | Sticky transmit-complete flag |
| rx_done_o | output | 1 | Sticky receive-complete flag |
| rx_byte_o | output | DATA_W | Last received byte |

## Verification
The bench uses the default DATA_W of 8. With eight bits, all 256 byte values can be sent and all 256 can be received in one run. Each transfer starts in a different slot of its machine cycle, which exercises both the one-cycle start delay and the alignment of bits to cycles. During receive, the data pin holds the wanted bit only in slot 9 and the inverse in every other slot. During both directions, stray writes and start requests are injected.

// File: rtl/serial_sync_pkg.sv
package serial_sync_pkg;
  localparam int unsigned SLOT_W          = 4;
  localparam int unsigned SLOTS           = 12;
  localparam int unsigned SLOT_S1P1       = 0;
  localparam int unsigned SLOT_CLK_LO_BEG = 4;
  localparam int unsigned SLOT_CLK_LO_END = 9;
  localparam int unsigned SLOT_S5P2       = 9;
  localparam int unsigned SLOT_S6P2       = 11;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic s1p1;
    logic s5p2;
    logic s6p2;
    logic clk_low;
  } slot_strobes_t;
endpackage

// File: rtl/serial_slot_timer.sv
module serial_slot_timer
  import serial_sync_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_i,
  output slot_strobes_t stb_o
);
  slot_t slot_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      slot_q <= '0;
    end else if (slot_q == slot_t'(SLOTS - 1)) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_q + slot_t'(1);
    end
  end

  always_comb begin
    stb_o.s1p1    = (slot_q == slot_t'(SLOT_S1P1));
    stb_o.s5p2    = (slot_q == slot_t'(SLOT_S5P2));
    stb_o.s6p2    = (slot_q == slot_t'(SLOT_S6P2));
    stb_o.clk_low = (slot_q >= slot_t'(SLOT_CLK_LO_BEG)) &&
                    (slot_q <= slot_t'(SLOT_CLK_LO_END));
  end
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import serial_sync_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  slot_strobes_t     stb_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              done_clr_i,
  output logic              busy_o,
  output logic              sending_o,
  output logic              bit_o,
  output logic              done_o
);
  localparam int unsigned SH_W = DATA_W + 1;

  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_ARM, TX_SEND} tx_stage_t;

  tx_stage_t       stage_q;
  logic [SH_W-1:0] sh_q;
  logic            last_q;
  logic            done_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage_q <= TX_IDLE;
      sh_q    <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (done_clr_i) done_q <= 1'b0;
      case (stage_q)
        TX_IDLE: begin
          if (load_i) begin
            sh_q    <= {1'b1, data_i};
            stage_q <= stb_i.s6p2 ? TX_ARM : TX_WAIT;
          end
        end
        TX_WAIT: if (stb_i.s6p2) stage_q <= TX_ARM;
        TX_ARM:  if (stb_i.s6p2) stage_q <= TX_SEND;
        TX_SEND: begin
          if (stb_i.s6p2) begin
            sh_q   <= {1'b0, sh_q[SH_W-1:1]};
            last_q <= (sh_q[SH_W-1:2] == '0) && sh_q[1];
          end
          if (stb_i.s1p1 && last_q) begin
            stage_q <= TX_IDLE;
            last_q  <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        default: stage_q <= TX_IDLE;
      endcase
    end
  end

  assign busy_o    = (stage_q != TX_IDLE);
  assign sending_o = (stage_q == TX_SEND);
  assign bit_o     = sh_q[0];
  assign done_o    = done_q;
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import serial_sync_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  slot_strobes_t     stb_i,
  input  logic              start_i,
  input  logic              sdat_i,
  input  logic              done_clr_i,
  output logic              busy_o,
  output logic              recv_o,
  output logic              done_o,
  output logic [DATA_W-1:0] byte_o
);
  typedef enum logic [2:0] {RX_IDLE, RX_WAIT, RX_PEND, RX_LOADED, RX_RECV} rx_stage_t;

  rx_stage_t         stage_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;
  logic [DATA_W-1:0] order_fix;
  logic [DATA_W-1:0] byte_q;
  logic              sample_q;
  logic              last_q;
  logic              done_q;

  assign sh_next = {sh_q[DATA_W-2:0], sample_q};

  // first bit taken in ends at the top of the register; buffer holds it at bit 0
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_order
    assign order_fix[gi] = sh_next[DATA_W-1-gi];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stage_q  <= RX_IDLE;
      sh_q     <= '1;
      byte_q   <= '0;
      sample_q <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (done_clr_i) done_q <= 1'b0;
      case (stage_q)
        RX_IDLE: if (start_i) stage_q <= stb_i.s6p2 ? RX_PEND : RX_WAIT;
        RX_WAIT: if (stb_i.s6p2) stage_q <= RX_PEND;
        RX_PEND: begin
          if (stb_i.s6p2) begin
            sh_q    <= {{(DATA_W-1){1'b1}}, 1'b0};
            stage_q <= RX_LOADED;
          end
        end
        RX_LOADED: stage_q <= RX_RECV;
        RX_RECV: begin
          if (stb_i.s5p2) sample_q <= sdat_i;
          if (stb_i.s6p2) begin
            sh_q <= sh_next;
            if (!sh_q[DATA_W-1]) begin
              byte_q <= order_fix;
              last_q <= 1'b1;
            end
          end
          if (stb_i.s1p1 && last_q) begin
            stage_q <= RX_IDLE;
            last_q  <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        default: stage_q <= RX_IDLE;
      endcase
    end
  end

  assign busy_o = (stage_q != RX_IDLE);
  assign recv_o = (stage_q == RX_RECV);
  assign done_o = done_q;
  assign byte_o = byte_q;
endmodule

// File: rtl/serial_sync_port.sv
module serial_sync_port
  import serial_sync_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rx_en_i,
  input  logic              tx_done_clr_i,
  input  logic              rx_done_clr_i,
  input  logic              sdat_i,
  output logic              sdat_o,
  output logic              sdat_oe_o,
  output logic              sclk_o,
  output logic              xmit_active_o,
  output logic              recv_active_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  slot_strobes_t stb;
  logic tx_busy, tx_sending, tx_bit, tx_done;
  logic rx_busy, rx_recv, rx_done;
  logic tx_load, rx_start;

  assign tx_load  = wr_i && !tx_busy && !rx_busy;
  assign rx_start = rx_en_i && !rx_done && !tx_busy && !wr_i;

  serial_slot_timer i_timer (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .stb_o (stb)
  );

  serial_tx_engine #(.DATA_W(DATA_W)) i_tx (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .stb_i      (stb),
    .load_i     (tx_load),
    .data_i     (wr_data_i),
    .done_clr_i (tx_done_clr_i),
    .busy_o     (tx_busy),
    .sending_o  (tx_sending),
    .bit_o      (tx_bit),
    .done_o     (tx_done)
  );

  serial_rx_engine #(.DATA_W(DATA_W)) i_rx (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .stb_i      (stb),
    .start_i    (rx_start),
    .sdat_i     (sdat_i),
    .done_clr_i (rx_done_clr_i),
    .busy_o     (rx_busy),
    .recv_o     (rx_recv),
    .done_o     (rx_done),
    .byte_o     (rx_byte_o)
  );

  assign sdat_o        = tx_sending ? tx_bit : 1'b1;
  assign sdat_oe_o     = tx_sending;
  assign sclk_o        = !((tx_sending || rx_recv) && stb.clk_low);
  assign xmit_active_o = tx_sending;
  assign recv_active_o = rx_recv;
  assign tx_done_o     = tx_done;
  assign rx_done_o     = rx_done;
endmodule

// File: rtl/serial_sync_port_chk.sv
module serial_sync_port_chk (
  input logic clk_i,
  input logic rst_i,
  input logic tx_done_clr_i,
  input logic rx_done_clr_i,
  input logic sdat_o,
  input logic sdat_oe_o,
  input logic sclk_o,
  input logic xmit_active_o,
  input logic recv_active_o,
  input logic tx_done_o,
  input logic rx_done_o
);
  logic [3:0] slot_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) slot_q <= 4'd0;
    else if (slot_q == 4'd11) slot_q <= 4'd0;
    else slot_q <= slot_q + 4'd1;
  end

  assert_half_duplex_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({xmit_active_o, recv_active_o}));

  assert_pin_released_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    recv_active_o |-> !sdat_oe_o);

  assert_sclk_window_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !sclk_o |-> ((xmit_active_o || recv_active_o) && slot_q >= 4'd4 && slot_q <= 4'd9));

  assert_xmit_start_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(xmit_active_o) |-> (slot_q == 4'd0));

  assert_xmit_end_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(xmit_active_o) |-> (tx_done_o && slot_q == 4'd1));

  assert_recv_start_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(recv_active_o) |-> (slot_q == 4'd1));

  assert_recv_end_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(recv_active_o) |-> (rx_done_o && slot_q == 4'd1));

  assert_bit_steady_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (xmit_active_o && $past(xmit_active_o) && slot_q != 4'd0) |-> $stable(sdat_o));

  assert_tx_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(tx_done_o) |-> $past(tx_done_clr_i));

  assert_rx_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rx_done_o) |-> $past(rx_done_clr_i));
endmodule

bind serial_sync_port serial_sync_port_chk i_chk (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .tx_done_clr_i (tx_done_clr_i),
  .rx_done_clr_i (rx_done_clr_i),
  .sdat_o        (sdat_o),
  .sdat_oe_o     (sdat_oe_o),
  .sclk_o        (sclk_o),
  .xmit_active_o (xmit_active_o),
  .recv_active_o (recv_active_o),
  .tx_done_o     (tx_done_o),
  .rx_done_o     (rx_done_o)
);

// File: tb/test_serial_sync_port.sv
module test_serial_sync_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       ren = 1'b0;
  logic       clr_tx = 1'b0;
  logic       clr_rx = 1'b0;
  logic       sdat_in = 1'b1;
  logic       sdat_out, sdat_oe, sclk, xmit, recv, tx_done, rx_done;
  logic [7:0] rx_byte;

  int checks = 0;
  int failures = 0;
  int clocks = 0;
  int bslot = 0;

  always #4 clk = ~clk;

  serial_sync_port #(.DATA_W(8)) i_serial_sync_port (
    .clk_i         (clk),
    .rst_i         (rst),
    .wr_i          (wr),
    .wr_data_i     (wdata),
    .rx_en_i       (ren),
    .tx_done_clr_i (clr_tx),
    .rx_done_clr_i (clr_rx),
    .sdat_i        (sdat_in),
    .sdat_o        (sdat_out),
    .sdat_oe_o     (sdat_oe),
    .sclk_o        (sclk),
    .xmit_active_o (xmit),
    .recv_active_o (recv),
    .tx_done_o     (tx_done),
    .rx_done_o     (rx_done),
    .rx_byte_o     (rx_byte)
  );

  // slot numbering expected from R1
  always @(posedge clk) begin
    if (rst) bslot <= 0;
    else bslot <= (bslot == 11) ? 0 : bslot + 1;
  end

  always @(posedge clk) begin
    clocks <= clocks + 1;
    if (clocks == 180000) begin
      failures = failures + 1;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", clocks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_slot(input int s);
    @(negedge clk);
    while (bslot != s) @(negedge clk);
  endtask

  function automatic int sclk_exp(input bit act, input int sl);
    return (act && sl >= 4 && sl <= 9) ? 0 : 1;
  endfunction

  task automatic tx_run(input logic [7:0] b, input int s);
    wait_slot(s);
    wr = 1'b1;
    wdata = b;
    for (int p = s + 1; p <= 121; p++) begin
      int cyc;
      int sl;
      bit xe;
      @(negedge clk);
      cyc = p / 12;
      sl = p % 12;
      xe = (p >= 24 && p <= 120);
      chk("R2/R5 xmit_active", int'(xmit), int'(xe));
      chk("R3 output enable", int'(sdat_oe), int'(xe));
      if (cyc >= 2 && cyc <= 9) chk("R3 data bit", int'(sdat_out), int'(b[cyc-2]));
      chk("R4 shift clock", int'(sclk), sclk_exp(xe, sl));
      chk("R5 tx_done", int'(tx_done), int'(p >= 121));
      chk("R10 no reception during send", int'(recv), 0);
      wr = (p == 60);
      wdata = ~b;
      ren = (p >= 30 && p <= 100);
      clr_tx = (p == 120);
    end
    wr = 1'b0;
    ren = 1'b0;
    clr_tx = 1'b0;
    repeat (12) @(negedge clk);
    chk("R9 tx_done sticky", int'(tx_done), 1);
    clr_tx = 1'b1;
    @(negedge clk);
    clr_tx = 1'b0;
    chk("R9 tx_done cleared", int'(tx_done), 0);
  endtask

  task automatic rx_run(input logic [7:0] b, input int s);
    wait_slot(s);
    ren = 1'b1;
    sdat_in = 1'b0;
    for (int p = s + 1; p <= 121; p++) begin
      int cyc;
      int sl;
      bit re;
      logic bitk;
      @(negedge clk);
      cyc = p / 12;
      sl = p % 12;
      re = (p >= 25 && p <= 120);
      chk("R6 recv_active", int'(recv), int'(re));
      chk("R8 pin released", int'(sdat_oe), 0);
      chk("R10 write ignored in receive", int'(xmit), 0);
      chk("R4 shift clock", int'(sclk), sclk_exp(re, sl));
      chk("R8 rx_done", int'(rx_done), int'(p >= 121));
      if (p == 121) chk("R7 received byte", int'(rx_byte), int'(b));
      bitk = (cyc >= 2 && cyc <= 9) ? b[cyc-2] : p[0];
      sdat_in = (sl == 9) ? bitk : ~bitk;
      wr = (p == 60);
      wdata = 8'h5A;
      clr_rx = (p == 120);
    end
    wr = 1'b0;
    clr_rx = 1'b0;
    sdat_in = 1'b1;
    repeat (24) @(negedge clk);
    chk("R9 no restart while rx_done", int'(recv), 0);
    chk("R9 byte kept", int'(rx_byte), int'(b));
    chk("R9 rx_done sticky", int'(rx_done), 1);
    ren = 1'b0;
    clr_rx = 1'b1;
    @(negedge clk);
    clr_rx = 1'b0;
    chk("R9 rx_done cleared", int'(rx_done), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 sclk in reset", int'(sclk), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 slot start", bslot, 1);
    chk("R1 sclk idle", int'(sclk), 1);
    chk("R1 oe idle", int'(sdat_oe), 0);
    chk("R1 xmit idle", int'(xmit), 0);
    chk("R1 recv idle", int'(recv), 0);
    chk("R1 tx_done idle", int'(tx_done), 0);
    chk("R1 rx_done idle", int'(rx_done), 0);
    chk("R1 rx_byte idle", int'(rx_byte), 0);

    for (int v = 0; v < 256; v++) tx_run(v[7:0], v % 12);
    for (int v = 0; v < 256; v++) rx_run(v[7:0], (v * 5) % 12);

    // write and start condition in the same slot: write wins (R10)
    wait_slot(3);
    wr = 1'b1;
    wdata = 8'hC3;
    ren = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    ren = 1'b0;
    repeat (26) @(negedge clk);
    chk("R10 write taken on tie", int'(xmit), 1);
    chk("R10 no reception on tie", int'(recv), 0);
    repeat (100) @(negedge clk);
    chk("R10 tie transfer done", int'(tx_done), 1);
    clr_tx = 1'b1;
    @(negedge clk);
    clr_tx = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule